// File: doc/BRIEF.md
# Strobed Serial Command Slave for an LED Panel Controller

This block is the host-facing front end of a multiplexed LED panel controller. A host microcontroller drives three lines: a strobe that frames each transfer (active low), a serial clock, and a serial data input. The block returns key-scan reports on an open-drain data output. All three inputs are brought into the system clock domain through two-flop synchronisers, and their edges are detected in that domain. Each strobe-low period is a frame. The first byte of a frame is a command, and its two most significant bits pick one of four command classes.

The command classes update the display-geometry register, the brightness and enable registers, the transfer-mode flags and the display-memory pointer. A frame that opens with a pointer command goes on to write its remaining bytes into a display memory of `RAM_DEPTH` bytes. This happens through a one-cycle write port, and the pointer either advances after each write or stays fixed. A frame that opens with a key-read transfer command instead streams report bytes out, least significant bit first. The block asks a neighbouring key-scan store for each byte through an index and a load pulse.

Top module: `strobe_cmd_slave`

## Requirements
- R1: After reset: geometry = 2'b11, brightness = 3'b000, display enable = 0, test flag = 0, pointer = 0, transfer mode = display write with auto-advance, data output released (`serDoutLow` = 0), no write pulse.
- R2: Serial data is captured on rising edges of the serial clock while the strobe is low, least significant bit first. The first byte after a falling strobe is a command whose bits 7:6 give the class: 00 geometry, 01 transfer setting, 10 display control, 11 pointer.
- R3: A geometry command (class 00) loads bits 1:0 into `dispMode`. If that value differs from the current one, `dispEnable` is cleared. If it is equal, nothing changes.
- R4: A display control command (class 10) loads bit 3 into `dispEnable` and bits 2:0 into `dimLevel`.
- R5: A pointer command (class 11) loads bits 3:0 as the pointer. In display-write mode, each following byte of the same frame is written to the pointer address, and the pointer then advances by one when the fixed flag is clear.
- R6: In a transfer setting command (class 01), bit 2 = 1 keeps the pointer fixed across writes, so repeated bytes all land on one address.
- R7: While the pointer is at `RAM_DEPTH` (14) or above, data bytes are dropped. Advancing past the last address does not wrap back to 0.
- R8: Raising the strobe in the middle of a byte discards the partial byte and restarts framing. Serial clock edges while the strobe is high have no effect.
- R9: A transfer setting command with bits 1:0 = 2'b10 selects key-read mode. The rest of that frame shifts report bytes out, starting at index 0. Each byte is loaded from `keyData` with one `keyLoad` pulse. `keyIdx` advances after each 8 clocks and wraps from `KEY_BYTES-1` to 0.
- R10: The data output is open drain. In key-read mode each falling serial clock edge presents the next bit, and a 0 bit is shown as `serDoutLow` = 1. The output is released whenever the strobe is high or no read is in progress.
- R11: Bit 3 of a transfer setting command sets `testMode`, and a 0 in that bit clears it.
- R12: These bytes are ignored: bytes that follow a geometry, display control or transfer setting write command in the same frame, and bytes that follow a pointer command while key-read mode is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serStb | input | 1 | Frame strobe from host, active low |
| serClk | input | 1 | Serial clock from host |
| serDin | input | 1 | Serial data from host |
| serDoutLow | output | 1 | Open-drain pull-down enable for the data output (1 = drive low) |
| keyData | input | 8 | Report byte at `keyIdx`, from the key-scan store |
| keyIdx | output | KIDX_W (2) | Index of the report byte being fetched |
| keyLoad | output | 1 | One-cycle pulse when `keyData` is taken |
| ramWrEn | output | 1 | Display memory write strobe |
| ramWrAddr | output | 4 | Display memory write address |
| ramWrData | output | 8 | Display memory write data |
| dispMode | output | 2 | Display geometry selection |
| dimLevel | output | 3 | Brightness step |
| dispEnable | output | 1 | Display on |
| testMode | output | 1 | Test flag from the transfer setting command |

## Verification
The assertions check several rules on every cycle: that every memory write stays inside the memory and that the pointer after a write matches the advance-or-hold setting; that a geometry change never leaves the display lit; that the data output is released and no byte completes while the strobe is high; and that the report index stays in range and is loaded only during a read frame. Only the bench scenarios can show what the frames do end to end. They show that the right bytes reach the right addresses in bit order, that the brightness and enable values follow each command, that an aborted partial byte is really lost, and that the serial bit stream read back on the data output reproduces the report bytes in order, including the wrap of the index.

// File: rtl/scs_pkg.sv
package scs_pkg;

  typedef enum logic [1:0] {
    CLS_MODE = 2'b00,
    CLS_XFER = 2'b01,
    CLS_CTRL = 2'b10,
    CLS_PTR  = 2'b11
  } cmdClass_t;

  typedef enum logic [1:0] {
    FR_CMD,
    FR_WRITE,
    FR_READ,
    FR_SKIP
  } frame_t;

  // control -> datapath
  typedef struct packed {
    logic loadOut;
    logic readPhase;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic       frameStart;
    logic       byteValid;
    logic [7:0] byteData;
  } dpEvent_t;

endpackage

// File: rtl/scs_datapath.sv
module scs_datapath
  import scs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       serStb,
  input  logic       serClk,
  input  logic       serDin,
  input  logic [7:0] keyData,
  input  ctlStrobe_t ctl,
  output dpEvent_t   ev,
  output logic       serDoutLow
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkSh, stbSh, dinSh;
  logic clkS, stbS, dinS;
  logic clkP, stbP;
  logic riseEv, fallEv;
  logic [2:0] bitCnt;
  logic [6:0] shIn;
  logic [7:0] shOut;
  logic       byteValidR;
  logic [7:0] byteDataR;
  logic       doutLowR;

  // synchronisers: idle values are strobe high, clock high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkSh <= {SYNC_STAGES{1'b1}};
      stbSh <= {SYNC_STAGES{1'b1}};
      dinSh <= '0;
    end else begin
      clkSh <= {clkSh[SYNC_STAGES-2:0], serClk};
      stbSh <= {stbSh[SYNC_STAGES-2:0], serStb};
      dinSh <= {dinSh[SYNC_STAGES-2:0], serDin};
    end
  end

  assign clkS = clkSh[LAST_STAGE];
  assign stbS = stbSh[LAST_STAGE];
  assign dinS = dinSh[LAST_STAGE];

  assign riseEv = ~stbS &  clkS & ~clkP;
  assign fallEv = ~stbS & ~clkS &  clkP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkP       <= 1'b1;
      stbP       <= 1'b1;
      bitCnt     <= '0;
      shIn       <= '0;
      shOut      <= '1;
      byteValidR <= 1'b0;
      byteDataR  <= '0;
      doutLowR   <= 1'b0;
    end else begin
      clkP       <= clkS;
      stbP       <= stbS;
      byteValidR <= 1'b0;
      if (stbS) begin
        // framing restarts, any partial byte is lost
        bitCnt   <= '0;
        doutLowR <= 1'b0;
      end else begin
        if (riseEv) begin
          shIn   <= {dinS, shIn[6:1]};
          bitCnt <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            byteValidR <= 1'b1;
            byteDataR  <= {dinS, shIn};
          end
        end
        if (ctl.loadOut) begin
          shOut <= keyData;
        end else if (fallEv && ctl.readPhase) begin
          shOut <= {1'b1, shOut[7:1]};
        end
        if (!ctl.readPhase) begin
          doutLowR <= 1'b0;
        end else if (fallEv && !ctl.loadOut) begin
          doutLowR <= ~shOut[0];
        end
      end
    end
  end

  assign ev         = {stbP & ~stbS, byteValidR, byteDataR};
  assign serDoutLow = doutLowR;

  // R10: the pull-down lets go whenever the strobe is seen high
  a_r10_release_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    stbS |=> !serDoutLow);

  // R8: no byte can complete while the strobe is high
  a_r8_no_byte_stb_high: assert property (@(posedge clk) disable iff (!rst_n)
    stbS |=> !ev.byteValid);

  // R2: a completed byte needs eight clock edges, so pulses never touch
  a_r2_byte_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ev.byteValid |=> !ev.byteValid);

endmodule

// File: rtl/scs_control.sv
module scs_control
  import scs_pkg::*;
#(
  parameter int RAM_DEPTH = 14,
  parameter int KEY_BYTES = 3,
  localparam int KIDX_W   = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpEvent_t          ev,
  output ctlStrobe_t        ctl,
  output logic [KIDX_W-1:0] keyIdx,
  output logic              keyLoad,
  output logic              ramWrEn,
  output logic [3:0]        ramWrAddr,
  output logic [7:0]        ramWrData,
  output logic [1:0]        dispMode,
  output logic [2:0]        dimLevel,
  output logic              dispEnable,
  output logic              testMode
);

  localparam logic [3:0]        LAST_ADDR = 4'(RAM_DEPTH - 1);
  localparam logic [KIDX_W-1:0] KLAST     = KIDX_W'(KEY_BYTES - 1);

  frame_t     frame;
  logic       keyRead;
  logic       addrFixed;
  logic [3:0] curAddr;
  logic       loadPend;
  logic [7:0] b;

  assign b = ev.byteData;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame      <= FR_SKIP;
      dispMode   <= 2'b11;
      dimLevel   <= 3'b000;
      dispEnable <= 1'b0;
      keyRead    <= 1'b0;
      addrFixed  <= 1'b0;
      testMode   <= 1'b0;
      curAddr    <= '0;
      ramWrEn    <= 1'b0;
      ramWrAddr  <= '0;
      ramWrData  <= '0;
      keyIdx     <= '0;
      loadPend   <= 1'b0;
    end else begin
      ramWrEn  <= 1'b0;
      loadPend <= 1'b0;
      if (ev.frameStart) begin
        frame <= FR_CMD;
      end else if (ev.byteValid) begin
        case (frame)
          FR_CMD: begin
            case (b[7:6])
              CLS_MODE: begin
                if (b[1:0] != dispMode) begin
                  dispMode   <= b[1:0];
                  dispEnable <= 1'b0;
                end
                frame <= FR_SKIP;
              end
              CLS_XFER: begin
                keyRead   <= (b[1:0] == 2'b10);
                addrFixed <= b[2];
                testMode  <= b[3];
                if (b[1:0] == 2'b10) begin
                  frame    <= FR_READ;
                  keyIdx   <= '0;
                  loadPend <= 1'b1;
                end else begin
                  frame <= FR_SKIP;
                end
              end
              CLS_CTRL: begin
                dispEnable <= b[3];
                dimLevel   <= b[2:0];
                frame      <= FR_SKIP;
              end
              default: begin
                curAddr <= b[3:0];
                frame   <= keyRead ? FR_SKIP : FR_WRITE;
              end
            endcase
          end
          FR_WRITE: begin
            if (curAddr <= LAST_ADDR) begin
              ramWrEn   <= 1'b1;
              ramWrAddr <= curAddr;
              ramWrData <= b;
              if (!addrFixed) curAddr <= curAddr + 4'd1;
            end
          end
          FR_READ: begin
            keyIdx   <= (keyIdx == KLAST) ? '0 : keyIdx + 1'b1;
            loadPend <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign keyLoad       = loadPend;
  assign ctl.loadOut   = loadPend;
  assign ctl.readPhase = (frame == FR_READ);

  a_r7_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ramWrEn |-> (ramWrAddr <= LAST_ADDR));

  a_r5_auto_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (ramWrEn && !addrFixed) |-> (curAddr == ramWrAddr + 4'd1));

  a_r6_fixed_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    (ramWrEn && addrFixed) |-> (curAddr == ramWrAddr));

  a_r3_change_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dispMode) |-> !dispEnable);

  a_r9_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    keyIdx <= KLAST);

  a_r9_load_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    keyLoad |-> (frame == FR_READ));

endmodule

// File: rtl/strobe_cmd_slave.sv
module strobe_cmd_slave
  import scs_pkg::*;
#(
  parameter int RAM_DEPTH   = 14,
  parameter int KEY_BYTES   = 3,
  parameter int SYNC_STAGES = 2,
  localparam int KIDX_W     = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serStb,
  input  logic              serClk,
  input  logic              serDin,
  output logic              serDoutLow,
  input  logic [7:0]        keyData,
  output logic [KIDX_W-1:0] keyIdx,
  output logic              keyLoad,
  output logic              ramWrEn,
  output logic [3:0]        ramWrAddr,
  output logic [7:0]        ramWrData,
  output logic [1:0]        dispMode,
  output logic [2:0]        dimLevel,
  output logic              dispEnable,
  output logic              testMode
);

  ctlStrobe_t ctl;
  dpEvent_t   ev;

  scs_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .serStb     (serStb),
    .serClk     (serClk),
    .serDin     (serDin),
    .keyData    (keyData),
    .ctl        (ctl),
    .ev         (ev),
    .serDoutLow (serDoutLow)
  );

  scs_control #(.RAM_DEPTH(RAM_DEPTH), .KEY_BYTES(KEY_BYTES)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev         (ev),
    .ctl        (ctl),
    .keyIdx     (keyIdx),
    .keyLoad    (keyLoad),
    .ramWrEn    (ramWrEn),
    .ramWrAddr  (ramWrAddr),
    .ramWrData  (ramWrData),
    .dispMode   (dispMode),
    .dimLevel   (dimLevel),
    .dispEnable (dispEnable),
    .testMode   (testMode)
  );

endmodule

// File: tb/strobe_cmd_slave_tb.sv
module strobe_cmd_slave_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serStb = 1'b1, serClk = 1'b1, serDin = 1'b0;
  logic serDoutLow;
  logic [7:0] keyData;
  logic [1:0] keyIdx;
  logic keyLoad, ramWrEn;
  logic [3:0] ramWrAddr;
  logic [7:0] ramWrData;
  logic [1:0] dispMode;
  logic [2:0] dimLevel;
  logic dispEnable, testMode;

  always #10 clk = ~clk;

  strobe_cmd_slave u_dut (
    .clk(clk), .rst_n(rst_n), .serStb(serStb), .serClk(serClk), .serDin(serDin),
    .serDoutLow(serDoutLow), .keyData(keyData), .keyIdx(keyIdx), .keyLoad(keyLoad),
    .ramWrEn(ramWrEn), .ramWrAddr(ramWrAddr), .ramWrData(ramWrData),
    .dispMode(dispMode), .dimLevel(dimLevel), .dispEnable(dispEnable), .testMode(testMode)
  );

  function automatic logic [7:0] keyPat(input int i);
    case (i)
      0: keyPat = 8'h3C;
      1: keyPat = 8'hA1;
      2: keyPat = 8'h5E;
      default: keyPat = 8'h00;
    endcase
  endfunction
  assign keyData = keyPat(int'(keyIdx));

  int checks = 0, errors = 0;
  int wrCount = 0, loadCount = 0, badDout = 0;
  logic readWin = 1'b0;
  logic done = 1'b0;
  logic [7:0] tbMem [16];

  initial for (int i = 0; i < 16; i++) tbMem[i] = 8'h00;

  always @(posedge clk) begin
    if (ramWrEn) begin
      tbMem[ramWrAddr] <= ramWrData;
      wrCount <= wrCount + 1;
    end
    if (keyLoad) loadCount <= loadCount + 1;
    if (serDoutLow && !readWin) badDout <= badDout + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      serClk = 1'b0; serDin = v[i]; waitc(8);
      serClk = 1'b1; waitc(8);
    end
  endtask

  task automatic readByte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      serClk = 1'b0; waitc(8);
      v[i] = ~serDoutLow;
      serClk = 1'b1; waitc(8);
    end
  endtask

  task automatic frameOpen();
    serStb = 1'b0; waitc(8);
  endtask

  task automatic frameClose();
    waitc(8); serStb = 1'b1; waitc(16);
  endtask

  task automatic frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3);
    frameOpen();
    sendByte(b0);
    if (n > 1) sendByte(b1);
    if (n > 2) sendByte(b2);
    if (n > 3) sendByte(b3);
    frameClose();
  endtask

  // {command, expected geometry, expected brightness, expected enable}
  localparam logic [13:0] VEC [10] = '{
    {8'h8A, 2'd3, 3'd2, 1'b1},
    {8'h8F, 2'd3, 3'd7, 1'b1},
    {8'h03, 2'd3, 3'd7, 1'b1},
    {8'h01, 2'd1, 3'd7, 1'b0},
    {8'h8B, 2'd1, 3'd3, 1'b1},
    {8'h00, 2'd0, 3'd3, 1'b0},
    {8'h00, 2'd0, 3'd3, 1'b0},
    {8'h88, 2'd0, 3'd0, 1'b1},
    {8'h02, 2'd2, 3'd0, 1'b0},
    {8'h87, 2'd2, 3'd7, 1'b0}
  };

  initial begin
    logic [7:0] rb;
    waitc(4);
    rst_n = 1'b1;
    waitc(4);

    // R1 reset state
    check("R1 dispMode", dispMode, 2'b11);
    check("R1 dimLevel", dimLevel, 3'b000);
    check("R1 dispEnable", dispEnable, 1'b0);
    check("R1 testMode", testMode, 1'b0);
    check("R1 serDoutLow", serDoutLow, 1'b0);
    check("R1 ramWrEn", ramWrEn, 1'b0);
    check("R1 keyIdx", keyIdx, 2'd0);

    // R3 R4 table of single-byte command frames
    for (int k = 0; k < 10; k++) begin
      frame(1, VEC[k][13:6], 8'h00, 8'h00, 8'h00);
      check($sformatf("R3/R4 vec%0d mode", k), dispMode, VEC[k][5:4]);
      check($sformatf("R3/R4 vec%0d dim", k), dimLevel, VEC[k][3:1]);
      check($sformatf("R3/R4 vec%0d en", k), dispEnable, VEC[k][0]);
    end

    // R1 default auto-advance then R2 R5 writes, LSB-first capture
    frame(4, 8'hC0, 8'h11, 8'h22, 8'h33);
    check("R5 mem0", tbMem[0], 8'h11);
    check("R2 mem1", tbMem[1], 8'h22);
    check("R5 mem2", tbMem[2], 8'h33);
    check("R5 count", wrCount, 3);

    // R7 last address then drop, no wrap
    frame(1, 8'h40, 8'h00, 8'h00, 8'h00);
    frame(4, 8'hCC, 8'h44, 8'h55, 8'h66);
    check("R7 mem12", tbMem[12], 8'h44);
    check("R7 mem13", tbMem[13], 8'h55);
    check("R7 mem14 untouched", tbMem[14], 8'h00);
    check("R7 no wrap mem0", tbMem[0], 8'h11);
    check("R7 count", wrCount, 5);
    frame(2, 8'hCF, 8'h77, 8'h00, 8'h00);
    check("R7 out of range", wrCount, 5);

    // R6 fixed pointer
    frame(1, 8'h44, 8'h00, 8'h00, 8'h00);
    frame(3, 8'hC5, 8'h10, 8'h20, 8'h00);
    check("R6 mem5", tbMem[5], 8'h20);
    check("R6 mem6", tbMem[6], 8'h00);
    check("R6 count", wrCount, 7);

    // R11 test flag
    frame(1, 8'h48, 8'h00, 8'h00, 8'h00);
    check("R11 set", testMode, 1'b1);
    frame(1, 8'h40, 8'h00, 8'h00, 8'h00);
    check("R11 clear", testMode, 1'b0);

    // R12 trailing bytes ignored
    frame(2, 8'h8C, 8'hC3, 8'h00, 8'h00);
    check("R12 dim", dimLevel, 3'd4);
    check("R12 en", dispEnable, 1'b1);
    check("R12 mode", dispMode, 2'd2);
    check("R12 no write after ctrl", wrCount, 7);
    frame(2, 8'h40, 8'h99, 8'h00, 8'h00);
    check("R12 no write after xfer", wrCount, 7);

    // R8 partial byte aborted, clocks ignored while strobe high
    frameOpen();
    serClk = 1'b0; serDin = 1'b1; waitc(8); serClk = 1'b1; waitc(8);
    serClk = 1'b0; serDin = 1'b0; waitc(8); serClk = 1'b1; waitc(8);
    serClk = 1'b0; serDin = 1'b1; waitc(8); serClk = 1'b1; waitc(8);
    serClk = 1'b0; serDin = 1'b1; waitc(8); serClk = 1'b1; waitc(8);
    serStb = 1'b1; waitc(16);
    for (int i = 0; i < 3; i++) begin
      serDin = 1'b1; serClk = 1'b0; waitc(8); serClk = 1'b1; waitc(8);
    end
    frame(1, 8'h89, 8'h00, 8'h00, 8'h00);
    check("R8 dim", dimLevel, 3'd1);
    check("R8 en", dispEnable, 1'b1);

    // R9 R10 key read, four bytes with index wrap
    readWin = 1'b1;
    frameOpen();
    sendByte(8'h42);
    readByte(rb); check("R9 byte0", rb, 8'h3C);
    readByte(rb); check("R9 byte1", rb, 8'hA1);
    readByte(rb); check("R9 byte2", rb, 8'h5E);
    readByte(rb); check("R9 byte3 wrap", rb, 8'h3C);
    frameClose();
    readWin = 1'b0;
    check("R9 loads", loadCount, 5);
    check("R9 index", keyIdx, 2'd1);
    check("R10 released", serDoutLow, 1'b0);
    check("R10 no pull outside read", badDout, 0);

    // R12 pointer frame ignored in key-read mode
    frame(2, 8'hC0, 8'h5A, 8'h00, 8'h00);
    check("R12 read mode blocks write", wrCount, 7);
    frame(1, 8'h40, 8'h00, 8'h00, 8'h00);
    frame(2, 8'hC1, 8'h5A, 8'h00, 8'h00);
    check("R5 write restored", tbMem[1], 8'h5A);
    check("R5 count restored", wrCount, 8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule